// File: doc/BRIEF.md
# Cache Snoop Responder with Line Writeback

This block is the processor-side half of a bus snoop. It holds a small direct-mapped cache as register files. There are sixteen lines of 32 bytes each, and every line carries a tag, a valid bit and a modified bit. When the system controller presents an inquire strobe with a 30-bit word address, the block looks the address up. It answers with an acknowledge, and that acknowledge also qualifies a hit-on-modified indication. If the line is dirty, the block goes through a fixed handshake with the controller. It first drives the inquired address back onto the address bus with a latch strobe. It then streams the whole line out as four 64-bit beats, and finally marks the line clean, or invalid if the snooping master intends to write.

Two narrow ports stand in for the processor's own traffic so the tag store can be populated. A fill port loads one 64-bit beat of a line, installs the tag and marks the line valid and clean. A store port writes one beat only when the address hits a valid line, and marks that line modified. The cache data path beyond these ports is not part of the block.

Top module: `inquire_responder`

## Requirements
- R1: While reset is held low, and in the first clock after its release, `hitm_n`, `ack_n` and `ale_n` are high and `addr_oe` and `data_oe` are low.
- R2: An inquire address hits when the valid line selected by address bits [8:5] has a tag equal to bits [31:9]. A dirty hit is a hit on a line whose modified bit is set. A tag mismatch on a dirty line is not a dirty hit.
- R3: In the clock after an inquire strobe is sampled, `hitm_n` is low exactly when the inquire is a dirty hit. It then stays low until the clock after the last writeback beat, and not longer.
- R4: Every sampled inquire produces a single-clock low pulse on `ack_n`, one clock after the `hitm_n` clock, that is, two clocks after the strobe.
- R5: On a miss or a clean hit, `hitm_n` stays high and no latch strobe or data beat follows. The block is then idle and ready for the next inquire.
- R6: On a dirty hit, `ale_n` goes low for one clock, two clocks after the first sampled `ctl_ack`. In that clock `addr_oe` is high and `addr_out` equals the inquired address bits [31:2]. `addr_oe` is low in every other clock.
- R7: One clock after the next sampled `ctl_ack` following the latch strobe, `data_oe` is high for four consecutive clocks. The beats carry the line's 64-bit words in ascending order of address bits [4:3], starting from 0. `data_oe` is low at all other times.
- R8: After the last beat, the line's modified bit is clear, so a later inquire is a clean hit and a store can mark it modified again. If `inq_wr` was high with the strobe, the line is also invalidated, so a later store to it is ignored and a later inquire misses.
- R9: An inquire strobe that arrives while an inquire is still in progress is ignored. It produces no acknowledge and changes no state.
- R10: A store whose address does not hit a valid line writes nothing and leaves the modified bit unchanged. When the fill and store strobes arrive in the same clock, the fill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fl_en | input | 1 | Fill one beat and install the line clean |
| fl_addr | input | 29 | Fill beat address, bits [31:3] |
| fl_data | input | 64 | Fill beat data |
| st_en | input | 1 | Store one beat on a hit and mark the line modified |
| st_addr | input | 29 | Store beat address, bits [31:3] |
| st_data | input | 64 | Store beat data |
| inq_strobe | input | 1 | Inquire strobe from the controller, active high |
| inq_addr | input | 30 | Inquire address, bits [31:2] |
| inq_wr | input | 1 | Snooping master intends to write: invalidate after writeback |
| ctl_ack | input | 1 | Controller acknowledge, active high |
| hitm_n | output | 1 | Hit on modified line, active low |
| ack_n | output | 1 | Inquire acknowledge qualifying `hitm_n`, active low |
| ale_n | output | 1 | Address latch strobe for the writeback, active low |
| addr_oe | output | 1 | Address bus output enable |
| addr_out | output | 30 | Writeback address, bits [31:2] |
| data_oe | output | 1 | Data bus output enable |
| data_out | output | 64 | Writeback beat data |

## Verification
A corrupted tag, valid bit or modified bit shows up within two clocks of the next inquire to that line, as a wrong level on `hitm_n` in the clock before the acknowledge. A modified bit that fails to clear shows up on the following inquire to the same line. A wrong line or beat index in the data path appears on `data_out` in the very beat it addresses. A state machine that loses the handshake shows up within one clock of the expected point, as a latch strobe, an output enable or an acknowledge in the wrong clock.

// File: rtl/inq_pkg.sv
// Shared types for the snoop responder.
// Assumes nothing beyond a single clock domain.
package inq_pkg;

    // Handshake phases of one inquire, in the order they occur.
    typedef enum logic [2:0] {
        S_IDLE,   // waiting for a strobe
        S_HIT,    // hit-modified indication clock
        S_ACK,    // acknowledge clock
        S_WAIT1,  // dirty: waiting for the controller's first acknowledge
        S_GAP,    // one clock between that acknowledge and the address re-drive
        S_ALE,    // address re-drive clock
        S_WAIT2,  // waiting for the controller's second acknowledge
        S_BEAT    // streaming beats out
    } inq_state_t;

endpackage

// File: rtl/inq_tag_store.sv
// Tag, valid and modified bits for a direct-mapped cache.
// Port A is the snoop lookup and port B is the store lookup; both are combinational.
// Per clock, a fill beats a modified-mark, and a post-writeback clear beats both.
// Assumes the caller keeps the fill, mark and clear indices stable around the edge.
module inq_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 23,
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    output logic             a_dirty,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    output logic             b_hit,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             clr_inval
);

    logic [TAG_W-1:0] tag_arr [LINES];
    logic [LINES-1:0] vld_v;
    logic [LINES-1:0] mod_v;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [TAG_W-1:0] tag_q;
        logic             vld_q;
        logic             mod_q;

        // Update this line's tag and state bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
                vld_q <= 1'b0;
                mod_q <= 1'b0;
            end else begin
                if (fill_en && fill_idx == IDX_W'(g)) begin
                    tag_q <= fill_tag;
                    vld_q <= 1'b1;
                    mod_q <= 1'b0;
                end else if (mark_en && mark_idx == IDX_W'(g)) begin
                    mod_q <= 1'b1;
                end
                if (clr_en && clr_idx == IDX_W'(g)) begin
                    mod_q <= 1'b0;
                    if (clr_inval) begin
                        vld_q <= 1'b0;
                    end
                end
            end
        end

        assign tag_arr[g] = tag_q;
        assign vld_v[g]   = vld_q;
        assign mod_v[g]   = mod_q;
    end

    // Snoop lookup: a dirty hit needs a valid line, a matching tag and the modified bit.
    always_comb begin
        a_dirty = vld_v[a_idx] && (tag_arr[a_idx] == a_tag) && mod_v[a_idx];
    end

    // Store lookup: a plain hit.
    always_comb begin
        b_hit = vld_v[b_idx] && (tag_arr[b_idx] == b_tag);
    end

endmodule

// File: rtl/inq_line_store.sv
// Data array holding every beat of every line: one write port and one combinational read port.
// Assumes the caller resolves write conflicts and needs no reset of the contents.
module inq_line_store #(
    parameter int IDX_W  = 4,
    parameter int BEATS  = 4,
    parameter int DATA_W = 64,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int WORDS  = (1 << IDX_W) * BEATS
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [BEAT_W-1:0] w_beat,
    input  logic [DATA_W-1:0] w_data,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic [BEAT_W-1:0] r_beat,
    output logic [DATA_W-1:0] r_data
);

    logic [DATA_W-1:0] mem [WORDS];

    // Write one beat.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[{w_idx, w_beat}] <= w_data;
        end
    end

    // Read the beat the sequencer currently selects.
    always_comb begin
        r_data = mem[{r_idx, r_beat}];
    end

endmodule

// File: rtl/inq_seq.sv
// Clock-by-clock handshake of one inquire: hit indication, acknowledge, wait for the
// controller, address re-drive, second wait, then the writeback beats.
// Strobes are sampled only when the sequencer is idle.
// Assumes snoop_dirty is the lookup result for the current inq_addr.
module inq_seq
    import inq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 4,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inq_strobe,
    input  logic [ADDR_W-1:2] inq_addr,
    input  logic              inq_wr,
    input  logic              snoop_dirty,
    input  logic              ctl_ack,
    output logic              hitm_n,
    output logic              ack_n,
    output logic              ale_n,
    output logic              addr_oe,
    output logic              data_oe,
    output logic [ADDR_W-1:2] addr_q,
    output logic [BEAT_W-1:0] beat_q,
    output logic              clr_en,
    output logic              clr_inval
);

    inq_state_t state_q;
    inq_state_t state_d;
    logic       dirty_q;
    logic       wr_q;
    logic       last_beat;

    assign last_beat = (beat_q == BEAT_W'(BEATS - 1));

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (inq_strobe) state_d = S_HIT;
            S_HIT:   state_d = S_ACK;
            S_ACK:   state_d = dirty_q ? S_WAIT1 : S_IDLE;
            S_WAIT1: if (ctl_ack) state_d = S_GAP;
            S_GAP:   state_d = S_ALE;
            S_ALE:   state_d = S_WAIT2;
            S_WAIT2: if (ctl_ack) state_d = S_BEAT;
            S_BEAT:  if (last_beat) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Phase register, inquire capture and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dirty_q <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && inq_strobe) begin
                dirty_q <= snoop_dirty;
                wr_q    <= inq_wr;
                addr_q  <= inq_addr;
            end
            if (state_q == S_BEAT) begin
                beat_q <= beat_q + 1'b1;
            end else begin
                beat_q <= '0;
            end
        end
    end

    // Output decode from the phase register.
    always_comb begin
        hitm_n    = !(dirty_q && state_q != S_IDLE);
        ack_n     = (state_q != S_ACK);
        ale_n     = (state_q != S_ALE);
        addr_oe   = (state_q == S_ALE);
        data_oe   = (state_q == S_BEAT);
        clr_en    = (state_q == S_BEAT) && last_beat;
        clr_inval = wr_q;
    end

endmodule

// File: rtl/inquire_responder.sv
// Top of the snoop responder: tag store, line store and handshake sequencer.
// The fill port installs clean lines. The store port modifies a line only on a hit.
// The inquire port runs the snoop handshake and writes back dirty lines.
// Assumes byte-addressed, line-aligned, direct-mapped placement.
module inquire_responder #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 4,
    parameter int BEATS  = 4,
    localparam int BYTE_OFF = $clog2(DATA_W / 8),
    localparam int BEAT_W   = $clog2(BEATS),
    localparam int OFF_W    = BYTE_OFF + BEAT_W,
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fl_en,
    input  logic [ADDR_W-1:BYTE_OFF] fl_addr,
    input  logic [DATA_W-1:0]        fl_data,
    input  logic                     st_en,
    input  logic [ADDR_W-1:BYTE_OFF] st_addr,
    input  logic [DATA_W-1:0]        st_data,
    input  logic                     inq_strobe,
    input  logic [ADDR_W-1:2]        inq_addr,
    input  logic                     inq_wr,
    input  logic                     ctl_ack,
    output logic                     hitm_n,
    output logic                     ack_n,
    output logic                     ale_n,
    output logic                     addr_oe,
    output logic [ADDR_W-1:2]        addr_out,
    output logic                     data_oe,
    output logic [DATA_W-1:0]        data_out
);

    logic              snoop_dirty;
    logic              st_hit;
    logic              st_take;
    logic              seq_ale_n;
    logic              seq_addr_oe;
    logic              seq_data_oe;
    logic [ADDR_W-1:2] seq_addr;
    logic [BEAT_W-1:0] seq_beat;
    logic              clr_en;
    logic              clr_inval;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BEAT_W-1:0] wr_beat;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    // A store takes effect only on a hit and only when no fill is present.
    assign st_take = st_en && st_hit && !fl_en;

    // Share the data array's single write port between fill and store.
    always_comb begin
        wr_en   = fl_en || st_take;
        wr_idx  = fl_en ? fl_addr[OFF_W+IDX_W-1:OFF_W] : st_addr[OFF_W+IDX_W-1:OFF_W];
        wr_beat = fl_en ? fl_addr[OFF_W-1:BYTE_OFF]    : st_addr[OFF_W-1:BYTE_OFF];
        wr_data = fl_en ? fl_data : st_data;
    end

    inq_tag_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_idx     (inq_addr[OFF_W+IDX_W-1:OFF_W]),
        .a_tag     (inq_addr[ADDR_W-1:OFF_W+IDX_W]),
        .a_dirty   (snoop_dirty),
        .b_idx     (st_addr[OFF_W+IDX_W-1:OFF_W]),
        .b_tag     (st_addr[ADDR_W-1:OFF_W+IDX_W]),
        .b_hit     (st_hit),
        .fill_en   (fl_en),
        .fill_idx  (fl_addr[OFF_W+IDX_W-1:OFF_W]),
        .fill_tag  (fl_addr[ADDR_W-1:OFF_W+IDX_W]),
        .mark_en   (st_take),
        .mark_idx  (st_addr[OFF_W+IDX_W-1:OFF_W]),
        .clr_en    (clr_en),
        .clr_idx   (seq_addr[OFF_W+IDX_W-1:OFF_W]),
        .clr_inval (clr_inval)
    );

    inq_line_store #(
        .IDX_W  (IDX_W),
        .BEATS  (BEATS),
        .DATA_W (DATA_W)
    ) u_lines (
        .clk    (clk),
        .we     (wr_en),
        .w_idx  (wr_idx),
        .w_beat (wr_beat),
        .w_data (wr_data),
        .r_idx  (seq_addr[OFF_W+IDX_W-1:OFF_W]),
        .r_beat (seq_beat),
        .r_data (rd_data)
    );

    inq_seq #(
        .ADDR_W (ADDR_W),
        .BEATS  (BEATS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .inq_strobe  (inq_strobe),
        .inq_addr    (inq_addr),
        .inq_wr      (inq_wr),
        .snoop_dirty (snoop_dirty),
        .ctl_ack     (ctl_ack),
        .hitm_n      (hitm_n),
        .ack_n       (ack_n),
        .ale_n       (seq_ale_n),
        .addr_oe     (seq_addr_oe),
        .data_oe     (seq_data_oe),
        .addr_q      (seq_addr),
        .beat_q      (seq_beat),
        .clr_en      (clr_en),
        .clr_inval   (clr_inval)
    );

    // Bus outputs: the buses read zero while their enables are off.
    always_comb begin
        ale_n    = seq_ale_n;
        addr_oe  = seq_addr_oe;
        data_oe  = seq_data_oe;
        addr_out = seq_addr_oe ? seq_addr : '0;
        data_out = seq_data_oe ? rd_data : '0;
    end

endmodule

// File: rtl/inq_chk.sv
// Protocol checks on the responder's ports, attached to every instance by bind.
// Assumes the controller acknowledge is sampled at the same clock edge as the block.
module inq_chk #(
    parameter int BEATS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic hitm_n,
    input logic ack_n,
    input logic ale_n,
    input logic addr_oe,
    input logic data_oe,
    input logic ctl_ack
);

    logic [7:0] run_q;

    // Count the length of the current data-enable run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= data_oe ? run_q + 1'b1 : '0;
        end
    end

    // R3
    hitm_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hitm_n) |=> !ack_n);

    // R3
    hitm_during_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !hitm_n);

    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> ack_n);

    // R5
    ale_needs_hitm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_n |-> !hitm_n);

    // R6
    ale_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_n |-> $past(ctl_ack, 2));

    // R6
    addr_oe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |=> !addr_oe);

    // R7
    beats_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe) |-> $past(ctl_ack));

    // R7
    beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_oe) |-> (run_q == 8'(BEATS)));

    // R7
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (run_q < 8'(BEATS)));

endmodule

bind inquire_responder inq_chk #(.BEATS(BEATS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hitm_n  (hitm_n),
    .ack_n   (ack_n),
    .ale_n   (ale_n),
    .addr_oe (addr_oe),
    .data_oe (data_oe),
    .ctl_ack (ctl_ack)
);

// File: tb/tb_inquire_responder.sv
// Sweeps every cache line through fill, store and inquire, and checks the handshake
// clock by clock against values computed from the line index and beat number.
module tb_inquire_responder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fl_en = 1'b0;
    logic [31:3] fl_addr = '0;
    logic [63:0] fl_data = '0;
    logic        st_en = 1'b0;
    logic [31:3] st_addr = '0;
    logic [63:0] st_data = '0;
    logic        inq_strobe = 1'b0;
    logic [31:2] inq_addr = '0;
    logic        inq_wr = 1'b0;
    logic        ctl_ack = 1'b0;
    logic        hitm_n;
    logic        ack_n;
    logic        ale_n;
    logic        addr_oe;
    logic [31:2] addr_out;
    logic        data_oe;
    logic [63:0] data_out;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    inquire_responder dut (
        .clk (clk), .rst_n (rst_n),
        .fl_en (fl_en), .fl_addr (fl_addr), .fl_data (fl_data),
        .st_en (st_en), .st_addr (st_addr), .st_data (st_data),
        .inq_strobe (inq_strobe), .inq_addr (inq_addr), .inq_wr (inq_wr),
        .ctl_ack (ctl_ack),
        .hitm_n (hitm_n), .ack_n (ack_n), .ale_n (ale_n),
        .addr_oe (addr_oe), .addr_out (addr_out),
        .data_oe (data_oe), .data_out (data_out)
    );

    function automatic logic [22:0] tg(int i);
        return 23'h01234 + 23'(i * 7);
    endfunction

    function automatic logic [63:0] fd(int i, int b);
        return {16'hD000 + 16'(i), 16'h5A5A, 16'hBEA0 + 16'(b), 16'(i * 4 + b)};
    endfunction

    function automatic logic [63:0] sd(int i, int b);
        return ~fd(i, b);
    endfunction

    function automatic logic [31:2] wa(int i, int o);
        return {tg(i), 4'(i), 3'(o)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic fill_line(input int i);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            fl_en = 1'b1; fl_addr = {tg(i), 4'(i), 2'(b)}; fl_data = fd(i, b);
        end
        @(negedge clk);
        fl_en = 1'b0;
    endtask

    task automatic store_line(input int i, input logic [22:0] t);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            st_en = 1'b1; st_addr = {t, 4'(i), 2'(b)}; st_data = sd(i, b);
        end
        @(negedge clk);
        st_en = 1'b0;
    endtask

    // One inquire: checks every clock of the handshake.
    task automatic inquire(input logic [31:2] a, input bit wr, input bit dirty, input int i,
                           input bit poke, input logic [31:2] pa);
        @(negedge clk);
        inq_strobe = 1'b1; inq_addr = a; inq_wr = wr;
        @(negedge clk);
        inq_strobe = 1'b0;
        chk(hitm_n == !dirty, "R2/R3 hitm_n after strobe", 64'(hitm_n), 64'(!dirty));
        chk(ack_n == 1'b1, "R4 ack_n before ack clock", 64'(ack_n), 64'd1);
        @(negedge clk);
        chk(ack_n == 1'b0, "R4 ack_n pulse", 64'(ack_n), 64'd0);
        chk(hitm_n == !dirty, "R3 hitm_n in ack clock", 64'(hitm_n), 64'(!dirty));
        @(negedge clk);
        chk(ack_n == 1'b1, "R4 ack_n released", 64'(ack_n), 64'd1);
        if (!dirty) begin
            for (int k = 0; k < 3; k++) begin
                chk(hitm_n && ale_n && !data_oe && !addr_oe, "R5 quiet after clean inquire",
                    {hitm_n, ale_n, data_oe, addr_oe}, 64'b1100);
                @(negedge clk);
            end
            return;
        end
        chk(hitm_n == 1'b0, "R3 hitm_n held while waiting", 64'(hitm_n), 64'd0);
        if (poke) begin
            inq_strobe = 1'b1; inq_addr = pa; inq_wr = 1'b0;
        end
        @(negedge clk);
        inq_strobe = 1'b0;
        chk(ale_n == 1'b1 && ack_n == 1'b1, "R6/R9 no strobe before controller ack",
            {ale_n, ack_n}, 64'b11);
        ctl_ack = 1'b1;
        @(negedge clk);
        ctl_ack = 1'b0;
        chk(ale_n == 1'b1, "R6 ale_n high in gap clock", 64'(ale_n), 64'd1);
        @(negedge clk);
        chk(ale_n == 1'b0 && addr_oe == 1'b1, "R6 ale clock", {ale_n, addr_oe}, 64'b01);
        chk(addr_out == a, "R6 writeback address", 64'(addr_out), 64'(a));
        @(negedge clk);
        chk(ale_n == 1'b1 && addr_oe == 1'b0 && data_oe == 1'b0, "R6 after ale clock",
            {ale_n, addr_oe, data_oe}, 64'b100);
        ctl_ack = 1'b1;
        @(negedge clk);
        ctl_ack = 1'b0;
        for (int b = 0; b < 4; b++) begin
            chk(data_oe == 1'b1, "R7 data_oe during beat", 64'(data_oe), 64'd1);
            chk(data_out == sd(i, b), "R7 beat data", data_out, sd(i, b));
            chk(hitm_n == 1'b0, "R3 hitm_n during beats", 64'(hitm_n), 64'd0);
            @(negedge clk);
        end
        chk(data_oe == 1'b0 && hitm_n == 1'b1, "R3/R7 release after last beat",
            {data_oe, hitm_n}, 64'b01);
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(ack_n && hitm_n, "R9 busy strobe left no trace", {ack_n, hitm_n}, 64'b11);
            end
        end
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        tests++;
        $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(hitm_n && ack_n && ale_n && !addr_oe && !data_oe, "R1 outputs in reset",
            {hitm_n, ack_n, ale_n, addr_oe, data_oe}, 64'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hitm_n && ack_n && ale_n && !addr_oe && !data_oe, "R1 outputs after reset",
            {hitm_n, ack_n, ale_n, addr_oe, data_oe}, 64'b11100);

        for (int i = 0; i < 16; i++) fill_line(i);
        for (int i = 0; i < 16; i++) begin
            if (i % 2 == 0) store_line(i, tg(i));
            else store_line(i, tg(i) + 23'd1);   // R10: tag mismatch, ignored
        end

        // R2: a tag mismatch on a dirty line is not a dirty hit.
        inquire({tg(2) + 23'd3, 4'd2, 3'd0}, 1'b0, 1'b0, 2, 1'b0, '0);

        // R2 R3 R7 R10: sweep every line, with the word offset varied.
        for (int i = 0; i < 16; i++) inquire(wa(i, i % 8), 1'b0, (i % 2 == 0), i, 1'b0, '0);

        // R8: the modified bit cleared after writeback.
        for (int i = 0; i < 6; i += 2) inquire(wa(i, 7), 1'b0, 1'b0, i, 1'b0, '0);

        // R8: an inquire with the write flag invalidates; a later store is ignored.
        store_line(2, tg(2));
        inquire(wa(2, 3), 1'b1, 1'b1, 2, 1'b0, '0);
        store_line(2, tg(2));
        inquire(wa(2, 3), 1'b0, 1'b0, 2, 1'b0, '0);

        // R8: after a read inquire the line stays valid and can be modified again.
        store_line(4, tg(4));
        inquire(wa(4, 1), 1'b0, 1'b1, 4, 1'b0, '0);

        // R9: a strobe during a busy inquire is ignored; line 8 is still dirty afterwards.
        store_line(6, tg(6));
        store_line(8, tg(8));
        inquire(wa(6, 0), 1'b0, 1'b1, 6, 1'b1, wa(8, 0));
        inquire(wa(8, 5), 1'b0, 1'b1, 8, 1'b0, '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule